// File: doc/BRIEF.md
# Timed Frequency-Offset Phase Slew Sequencer

This block turns a signed phase-step request into two actions on a clock generator. The first is an optional instant jump of the power-of-two output divider by a whole number of its input cycles. The second is a timed interval during which the synthesizer runs slightly off frequency at a fixed offset, so that the output phase drifts by the remaining amount. The interval length in timebase ticks is worked out from the residual phase, the current output period and a fixed gain. The gain stands for the reciprocal of the offset, so it is 200000 for a 5 ppm offset.

The phase is a signed fraction of one output cycle, and 65536 counts as a full cycle. When the output frequency is high (the low-frequency flag is clear), the whole step is slewed. When the flag is set, the step is first split against the divider ratio 2^n. The whole divider-input cycles go out as a one-cycle jump command, and only the fractional remainder is slewed. A controller issues one request at a time and waits for busy to drop before sending the next.

The sequencer is a five-state machine:
- IDLE accepts a request and moves to LOAD.
- LOAD loads the interval counter. From there it goes to JUMP when the jump count is nonzero, to SLEW when the interval is nonzero, and to FINISH otherwise.
- JUMP pulses the jump command for one cycle, then goes to SLEW, or to FINISH when the interval is zero.
- SLEW holds the offset enable and counts ticks down. On the tick that takes the count from 1 to 0 it goes to FINISH.
- FINISH always returns to IDLE.

Top module: `slew_seq`

## Requirements
- R1: After reset, busy, offset_en, jump_valid, jump_back and slew_neg are all 0.
- R2: A request (req_valid high) seen while busy is low is accepted at that clock edge, and busy is high from the next cycle on.
- R3: A phase magnitude above 65536 (one full cycle) is clamped to 65536 and keeps its sign.
- R4: With low_freq = 0 no jump is issued, and the slewed amount is the whole clamped magnitude.
- R5: With low_freq = 1 and n = min(div_log2, 16), the jump count is magnitude >> (16 - n). The slewed residual is the low (16 - n) bits of the magnitude.
- R6: A nonzero jump count is issued as exactly one jump_valid cycle, before any offset interval. jump_count carries the count, and jump_back = 1 marks a negative step. A zero count issues no pulse.
- R7: offset_en stays high for exactly floor(residual * period * SLEW_GAIN / 65536) tick pulses. When that value is 0, offset_en never rises.
- R8: slew_neg is 1 for a negative request and 0 otherwise, and it does not change while offset_en is high.
- R9: busy falls exactly one clock after the last cycle in which offset_en is high.
- R10: A request arriving while busy is high is ignored. It changes neither the interval nor the sign, and it starts no later sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe, one clock wide, which paces the interval |
| req_valid | input | 1 | Phase-step request strobe |
| req_phase | input | 18 | Signed step, 65536 = one full cycle |
| low_freq | input | 1 | 1 = split into a divider jump plus a residual slew |
| div_log2 | input | 5 | Divider exponent n (ratio 2^n), saturated at 16 |
| period | input | 16 | Current output period in timebase ticks |
| offset_en | output | 1 | Run the synthesizer at the offset frequency |
| slew_neg | output | 1 | Direction of the offset (1 = retard) |
| jump_valid | output | 1 | One-cycle divider jump command |
| jump_count | output | 17 | Divider input cycles to jump |
| jump_back | output | 1 | Jump direction (1 = backward) |
| busy | output | 1 | Sequence in progress |

## Verification
A fault in the interval counter shows up at the ports as an offset window that holds the wrong number of ticks. It can be seen by the end of that window, at most a few hundred ticks after the request. A wrong state transition shows up within a cycle or two as one of three things: a missing or doubled jump pulse, a jump that lands after the offset window, or busy dropping early or late against the falling edge of offset_en. A wrong split or clamp gives a jump count or residual window that differs from the values worked out from the request. Each directed scenario compares these counts against the values that follow from the requirements.

// File: rtl/slew_pkg.sv
package slew_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_JUMP,
        S_SLEW,
        S_FINISH
    } seq_state_t;
endpackage

// File: rtl/step_split.sv
module step_split #(
    parameter int FRAC_W = 16,
    parameter int PH_W   = 18,
    parameter int NSEL_W = 5,
    localparam int MAG_W = FRAC_W + 1
) (
    input  logic signed [PH_W-1:0] phase,
    input  logic                   low_freq,
    input  logic [NSEL_W-1:0]      div_log2,
    output logic                   neg,
    output logic [MAG_W-1:0]       jump_cnt,
    output logic [MAG_W-1:0]       residual
);
    localparam logic [PH_W-1:0] FULL = {{(PH_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

    logic [PH_W-1:0]   absval;
    logic [MAG_W-1:0]  mag;
    logic [NSEL_W-1:0] n_eff;
    logic [NSEL_W-1:0] sh;
    logic [MAG_W-1:0]  mask;

    always_comb begin
        absval   = phase[PH_W-1] ? PH_W'(-phase) : PH_W'(phase);
        mag      = (absval > FULL) ? FULL[MAG_W-1:0] : absval[MAG_W-1:0];
        neg      = phase[PH_W-1];
        n_eff    = (div_log2 > NSEL_W'(FRAC_W)) ? NSEL_W'(FRAC_W) : div_log2;
        sh       = NSEL_W'(FRAC_W) - n_eff;
        mask     = (MAG_W'(1) << sh) - MAG_W'(1);
        jump_cnt = low_freq ? (mag >> sh) : '0;
        residual = low_freq ? (mag & mask) : mag;
    end
endmodule

// File: rtl/interval_calc.sv
module interval_calc #(
    parameter int FRAC_W    = 16,
    parameter int PER_W     = 16,
    parameter int SLEW_GAIN = 200000,
    parameter int CNT_W     = 35,
    localparam int MAG_W    = FRAC_W + 1,
    localparam int PROD_W   = CNT_W + FRAC_W
) (
    input  logic [MAG_W-1:0] residual,
    input  logic [PER_W-1:0] period,
    output logic [CNT_W-1:0] interval
);
    logic [PROD_W-1:0] prod;

    always_comb begin
        prod     = PROD_W'(residual) * PROD_W'(period) * PROD_W'(SLEW_GAIN);
        interval = prod[PROD_W-1:FRAC_W];
    end
endmodule

// File: rtl/slew_timer.sv
module slew_timer #(
    parameter int CNT_W = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             dec,
    output logic             is_zero,
    output logic             is_last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (dec) cnt <= cnt - CNT_W'(1);
    end

    assign is_zero = (cnt == '0);
    assign is_last = (cnt == CNT_W'(1));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt != '0);
endmodule

// File: rtl/slew_seq.sv
module slew_seq #(
    parameter int FRAC_W    = 16,
    parameter int PH_W      = 18,
    parameter int PER_W     = 16,
    parameter int NSEL_W    = 5,
    parameter int SLEW_GAIN = 200000,
    localparam int MAG_W    = FRAC_W + 1,
    localparam int GAIN_W   = $clog2(SLEW_GAIN + 1),
    localparam int CNT_W    = MAG_W + PER_W + GAIN_W - FRAC_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   req_valid,
    input  logic signed [PH_W-1:0] req_phase,
    input  logic                   low_freq,
    input  logic [NSEL_W-1:0]      div_log2,
    input  logic [PER_W-1:0]       period,
    output logic                   offset_en,
    output logic                   slew_neg,
    output logic                   jump_valid,
    output logic [MAG_W-1:0]       jump_count,
    output logic                   jump_back,
    output logic                   busy
);
    import slew_pkg::*;

    seq_state_t state, state_nx;

    logic             split_neg;
    logic [MAG_W-1:0] split_jump, split_res;
    logic             neg_q;
    logic [MAG_W-1:0] jump_q, res_q;
    logic [PER_W-1:0] period_q;
    logic [CNT_W-1:0] interval;
    logic             cnt_zero, cnt_last;
    logic             accept, ld, dec;

    step_split #(.FRAC_W(FRAC_W), .PH_W(PH_W), .NSEL_W(NSEL_W)) u_split (
        .phase    (req_phase),
        .low_freq (low_freq),
        .div_log2 (div_log2),
        .neg      (split_neg),
        .jump_cnt (split_jump),
        .residual (split_res)
    );

    interval_calc #(.FRAC_W(FRAC_W), .PER_W(PER_W), .SLEW_GAIN(SLEW_GAIN), .CNT_W(CNT_W)) u_calc (
        .residual (res_q),
        .period   (period_q),
        .interval (interval)
    );

    slew_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (ld),
        .ld_val  (interval),
        .dec     (dec),
        .is_zero (cnt_zero),
        .is_last (cnt_last)
    );

    assign accept = (state == S_IDLE) && req_valid;
    assign ld     = (state == S_LOAD);
    assign dec    = (state == S_SLEW) && tick;

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q    <= 1'b0;
            jump_q   <= '0;
            res_q    <= '0;
            period_q <= '0;
        end else if (accept) begin
            neg_q    <= split_neg;
            jump_q   <= split_jump;
            res_q    <= split_res;
            period_q <= period;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_nx = S_LOAD;
            S_LOAD: begin
                if (jump_q != '0)        state_nx = S_JUMP;
                else if (interval != '0) state_nx = S_SLEW;
                else                     state_nx = S_FINISH;
            end
            S_JUMP:   state_nx = cnt_zero ? S_FINISH : S_SLEW;
            S_SLEW:   if (tick && cnt_last) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state != S_IDLE);
        offset_en  = (state == S_SLEW);
        jump_valid = (state == S_JUMP);
        jump_count = jump_q;
        jump_back  = neg_q;
        slew_neg   = neg_q;
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    // R6
    jump_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_valid |=> !jump_valid);
    // R6
    jump_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_valid |-> (jump_count != '0) && !offset_en);
    // R8
    sign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_en && $past(offset_en)) |-> $stable(slew_neg));
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(offset_en) |-> busy);
    // R9
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(offset_en) |=> !busy);
endmodule

// File: tb/tb_slew_seq.sv
module tb_slew_seq;
    localparam int GAIN = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               tick = 1'b0;
    logic               req_valid = 1'b0;
    logic signed [17:0] req_phase = '0;
    logic               low_freq = 1'b0;
    logic [4:0]         div_log2 = '0;
    logic [15:0]        period = '0;
    logic               offset_en, slew_neg, jump_valid, jump_back, busy;
    logic [16:0]        jump_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // monitor state
    int  m_ticks, m_jumps, m_sign_err, m_busy_err, m_order_err;
    longint m_jcount;
    bit  m_jdir, m_sign, m_prev_off, m_fell;

    slew_seq #(.SLEW_GAIN(GAIN)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
        .req_phase(req_phase), .low_freq(low_freq), .div_log2(div_log2),
        .period(period), .offset_en(offset_en), .slew_neg(slew_neg),
        .jump_valid(jump_valid), .jump_count(jump_count), .jump_back(jump_back),
        .busy(busy)
    );

    always #5 clk = ~clk;

    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    always @(negedge clk) begin
        if (offset_en && tick) m_ticks++;
        if (offset_en && m_prev_off && slew_neg != m_sign) m_sign_err++;
        if (offset_en) m_sign = slew_neg;
        if (jump_valid) begin
            m_jumps++;
            m_jcount = longint'(jump_count);
            m_jdir   = jump_back;
            if (m_ticks != 0) m_order_err++;
        end
        if (m_fell && busy) m_busy_err++;
        m_fell = 1'b0;
        if (m_prev_off && !offset_en) begin
            if (!busy) m_busy_err++;
            m_fell = 1'b1;
        end
        m_prev_off = offset_en;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        m_ticks = 0; m_jumps = 0; m_sign_err = 0; m_busy_err = 0;
        m_order_err = 0; m_jcount = 0; m_jdir = 0; m_sign = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    // one request, checked against the requirement model
    task automatic run_req(input longint ph, input int per, input bit lowf, input int n, input string tag);
        longint mag, jexp, rexp, iexp;
        int nn, sh;
        bit neg;
        neg = (ph < 0);
        mag = neg ? -ph : ph;
        if (mag > 65536) mag = 65536;                 // R3
        if (lowf) begin                                // R5
            nn = (n > 16) ? 16 : n;
            sh = 16 - nn;
            jexp = mag >> sh;
            rexp = mag & ((longint'(1) << sh) - 1);
        end else begin                                 // R4
            jexp = 0;
            rexp = mag;
        end
        iexp = (rexp * per * GAIN) >> 16;              // R7
        @(negedge clk);
        clear_mon();
        req_phase = 18'(ph); period = 16'(per); low_freq = lowf; div_log2 = 5'(n);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, {tag, " R2 busy after accept"}, busy, 1);
        wait_idle();
        chk(m_ticks == iexp, {tag, " R7 offset ticks"}, m_ticks, iexp);
        chk(m_jumps == (jexp != 0 ? 1 : 0), {tag, " R6 jump pulses"}, m_jumps, (jexp != 0 ? 1 : 0));
        if (jexp != 0) begin
            chk(m_jcount == jexp, {tag, " R5 jump count"}, m_jcount, jexp);
            chk(m_jdir == neg, {tag, " R6 jump direction"}, m_jdir, neg);
            chk(m_order_err == 0, {tag, " R6 jump before slew"}, m_order_err, 0);
        end
        if (iexp != 0) begin
            chk(m_sign == neg, {tag, " R8 slew sign"}, m_sign, neg);
            chk(m_sign_err == 0, {tag, " R8 sign stable"}, m_sign_err, 0);
            chk(m_busy_err == 0, {tag, " R9 busy release"}, m_busy_err, 0);
        end
    endtask

    task automatic t_reset();
        chk(busy == 0, "R1 busy", busy, 0);
        chk(offset_en == 0, "R1 offset_en", offset_en, 0);
        chk(jump_valid == 0, "R1 jump_valid", jump_valid, 0);
        chk(jump_back == 0 && slew_neg == 0, "R1 direction outputs", slew_neg, 0);
    endtask

    task automatic t_ignore_busy();
        int prior;
        @(negedge clk);
        clear_mon();
        req_phase = 18'sd16384; period = 16'd100; low_freq = 1'b0; div_log2 = '0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        req_phase = -18'sd65536; period = 16'd400; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        chk(m_ticks == 125, "R10 interval unchanged", m_ticks, 125);
        chk(m_sign == 1'b0, "R10 sign unchanged", m_sign, 0);
        prior = m_ticks;
        repeat (5) @(negedge clk);
        chk(busy == 0 && m_ticks == prior, "R10 no later sequence", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_req(16384, 100, 0, 0, "high quarter");        // 125 ticks
        run_req(-65536, 40, 0, 0, "high full neg");       // 200 ticks
        run_req(100000, 40, 0, 0, "R3 clamp");            // 200 ticks
        run_req(50000, 64, 1, 4, "low split");            // jump 12, 4 ticks
        run_req(-30000, 1000, 1, 8, "low neg");           // jump 117, 3 ticks
        run_req(8192, 100, 1, 4, "low exact");            // jump 2, no slew
        run_req(1234, 100, 1, 20, "low n clamp");         // jump 1234
        run_req(10, 10, 0, 0, "zero interval");           // nothing
        run_req(65536, 30, 1, 0, "low full n0");          // jump 1, no slew
        t_ignore_busy();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule